// File: doc/BRIEF.md
# Three-Phase Centre-Aligned PWM with Sample-Window Trigger

This block drives the high-side and low-side gate signals of a three-phase inverter bridge. A symmetric up/down carrier counter is compared with a duty value for each phase. Dead time is inserted around every switching edge, so the two switches of a leg are never on together. One clock of `ready` marks the start of every PWM cycle, and the control core can load its next set of duty values at that point. Duty values written at any other time are held back until the next cycle boundary.

At each cycle start the block works out the switching instants of all three phases. It then finds the first stretch of the cycle in which no gate changes and which is at least the programmed acquisition time long. An ADC trigger pulse fires at the centre of that stretch. If no stretch is long enough, the block raises `no_sample` for the whole cycle and sends no trigger.

Top module: `tri_pwm_sampler`

## Requirements
- R1: `ready` is high for exactly one clock at the start of each PWM cycle. A cycle lasts 2^(W+1) clocks. Offsets are counted in clocks from the `ready` clock, which is offset 0.
- R2: For a duty value d with 0 < d < 2^W-1, the ideal switching signal of a phase is on while the carrier is below d. The ideal signal falls at offset d and rises again at offset 2^(W+1)-d. The gate outputs follow the ideal signal one clock later.
- R3: After every edge of the ideal signal, both gates of that phase stay off for exactly D clocks, where D is `dead_time`. When D = 0 the two gates swap in the same clock.
- R4: The high-side and low-side gates of a phase are never on at the same time.
- R5: A duty value of 0 keeps the low-side gate on for the whole cycle. A duty value of all ones (2^W-1) keeps the high-side gate on for the whole cycle. Neither case produces a dead-time gap, as long as the previous cycle used the same value.
- R6: Duty values are taken only at the cycle boundary. A change in the middle of a cycle has no effect on the gates until the next `ready`.
- R7: The switching instants of all phases that have neither a zero nor an all-ones duty are sorted in time. The block takes the first gap between consecutive instants whose length L is greater than 0 and not less than `acq_time`. If that gap starts at offset s, `adc_trig` pulses for one clock at offset s + floor(L/2).
- R8: When no gap qualifies, `no_sample` is high from offset 1 to the next `ready`, and `adc_trig` stays low. When a gap does qualify, `no_sample` is low over the same span.
- R9: While `rst_n` is low, all high-side gates are off, all low-side gates are on, and `adc_trig` and `no_sample` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_u | input | W | Duty value for phase U |
| duty_v | input | W | Duty value for phase V |
| duty_w | input | W | Duty value for phase W |
| dead_time | input | DT_W | Dead time in clocks |
| acq_time | input | AQ_W | Minimum stable window for sampling, in clocks |
| ready | output | 1 | One-clock pulse at the start of each cycle |
| gate_hi | output | 3 | High-side gates, bit 0 = U, bit 1 = V, bit 2 = W |
| gate_lo | output | 3 | Low-side gates, same bit order |
| adc_trig | output | 1 | One-clock ADC sampling trigger |
| no_sample | output | 1 | No qualifying window in this cycle |

## Verification
Some properties can be checked on every clock, and the embedded assertions cover them:
- the two gates of a leg never conduct together;
- both gates are off in the clock right after a high-side turn-off whenever dead time is non-zero;
- `ready` and `adc_trig` are single-clock pulses;
- a trigger never coincides with `no_sample`.

Other behaviour can only be shown by the bench's scenarios, because it depends on the exact offsets within a cycle:
- where each edge lands;
- the exact length of the dead-time gap;
- which window is chosen, and its centre;
- that duty values are held until the cycle boundary;
- the steady outputs for zero and full duty.

// File: rtl/tri_pwm_sampler.sv
`timescale 1ns/1ps
module tri_pwm_sampler #(
  parameter int W    = 15,
  parameter int DT_W = 9,
  parameter int AQ_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    duty_u,
  input  logic [W-1:0]    duty_v,
  input  logic [W-1:0]    duty_w,
  input  logic [DT_W-1:0] dead_time,
  input  logic [AQ_W-1:0] acq_time,
  output logic            ready,
  output logic [2:0]      gate_hi,
  output logic [2:0]      gate_lo,
  output logic            adc_trig,
  output logic            no_sample
);
  localparam int PW = W + 1;
  localparam int CW = ((PW > AQ_W) ? PW : AQ_W) + 1;
  localparam logic [W-1:0]  FULL = {W{1'b1}};
  localparam logic [PW-1:0] LAST = {PW{1'b1}};
  localparam logic [PW-1:0] APEX = {1'b1, {W{1'b0}}};

  logic [PW-1:0]       pos;
  logic [W-1:0]        car;
  logic [2:0][W-1:0]   din, dact;
  logic [2:0]          ideal, act;
  logic [PW-1:0]       tgt_q, tgt_n;
  logic                tgt_v, hit;

  assign din   = {duty_w, duty_v, duty_u};
  assign car   = pos[W] ? ~pos[W-1:0] : pos[W-1:0];
  assign ready = (pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      dact <= '0;
    end else begin
      pos <= pos + 1'b1;
      if (pos == LAST) dact <= din;
    end
  end

  function automatic logic fits(input logic [CW-1:0] len, input logic [AQ_W-1:0] aq);
    return (len != '0) && (len >= CW'(aq));
  endfunction

  logic [W-1:0]  mn, sa, sb, sc, t;
  logic [CW-1:0] l01, l12, lmid;

  always_comb begin
    mn = FULL;
    for (int i = 0; i < 3; i++)
      if (act[i] && dact[i] < mn) mn = dact[i];
    sa = act[0] ? dact[0] : mn;
    sb = act[1] ? dact[1] : mn;
    sc = act[2] ? dact[2] : mn;
    t  = '0;
    if (sa > sb) begin t = sa; sa = sb; sb = t; end
    if (sb > sc) begin t = sb; sb = sc; sc = t; end
    if (sa > sb) begin t = sa; sa = sb; sb = t; end
    l01  = CW'(sb) - CW'(sa);
    l12  = CW'(sc) - CW'(sb);
    lmid = (CW'(APEX) - CW'(sc)) << 1;
    hit   = 1'b0;
    tgt_n = '0;
    if (|act) begin
      if (fits(l01, acq_time)) begin
        hit = 1'b1; tgt_n = PW'(CW'(sa) + (l01 >> 1));
      end else if (fits(l12, acq_time)) begin
        hit = 1'b1; tgt_n = PW'(CW'(sb) + (l12 >> 1));
      end else if (fits(lmid, acq_time)) begin
        hit = 1'b1; tgt_n = APEX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q     <= '0;
      tgt_v     <= 1'b0;
      no_sample <= 1'b0;
    end else if (ready) begin
      tgt_q     <= tgt_n;
      tgt_v     <= hit;
      no_sample <= !hit;
    end
  end

  assign adc_trig = tgt_v && (pos == tgt_q) && (pos != '0);

  for (genvar i = 0; i < 3; i++) begin : g_ph
    logic            prev;
    logic [DT_W-1:0] dtc;

    assign act[i]   = (dact[i] != '0) && (dact[i] != FULL);
    assign ideal[i] = (dact[i] == FULL) || (car < dact[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev <= 1'b0;
        dtc  <= '0;
      end else begin
        prev <= ideal[i];
        if (ideal[i] != prev) dtc <= dead_time;
        else if (dtc != '0)   dtc <= dtc - DT_W'(1);
      end
    end

    assign gate_hi[i] = prev && (dtc == '0);
    assign gate_lo[i] = !prev && (dtc == '0);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[i] && gate_lo[i]));
    a_r3_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_hi[i]) && $past(dead_time) != '0) |-> !gate_lo[i]);
  end

  a_r1_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  a_r7_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);
  a_r8_trig_excl: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> !no_sample);
endmodule

// File: tb/tri_pwm_sampler_bench.sv
`timescale 1ns/1ps
module tri_pwm_sampler_bench;
  localparam int W   = 5;
  localparam int PER = 1 << (W + 1);
  localparam int MX  = (1 << W) - 1;
  localparam int D   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] duty_u = '0, duty_v = '0, duty_w = '0;
  logic [8:0]   dead_time = 9'(D);
  logic [14:0]  acq_time = 15'd1;
  logic ready, adc_trig, no_sample;
  logic [2:0] gate_hi, gate_lo;

  always #10 clk = ~clk;

  tri_pwm_sampler #(.W(W), .DT_W(9), .AQ_W(15)) u_tri_pwm_sampler (
    .clk(clk), .rst_n(rst_n), .duty_u(duty_u), .duty_v(duty_v), .duty_w(duty_w),
    .dead_time(dead_time), .acq_time(acq_time), .ready(ready), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .adc_trig(adc_trig), .no_sample(no_sample));

  int checks = 0, failures = 0;
  logic [2:0] c_hi [PER];
  logic [2:0] c_lo [PER];
  logic       c_tr [PER];
  logic       c_ns [PER];
  logic       c_rd [PER];

  // du, dv, dw, acq, expected trigger offset (-1: none)
  localparam int VEC [8][5] = '{
    '{8, 16, 24, 4, 12}, '{8, 16, 24, 10, 32}, '{10, 11, 12, 3, 32},
    '{0, 0, 0, 1, -1},   '{31, 0, 5, 4, 32},   '{20, 20, 4, 2, 12},
    '{30, 29, 31, 5, -1}, '{3, 9, 2, 0, 2}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!ready);
  endtask

  task automatic capture(input int chg_at, input int chg_val);
    wait_start();
    for (int k = 0; k < PER; k++) begin
      if (k > 0) @(negedge clk);
      c_hi[k] = gate_hi; c_lo[k] = gate_lo;
      c_tr[k] = adc_trig; c_ns[k] = no_sample; c_rd[k] = ready;
      if (k == chg_at) duty_u = W'(chg_val);
    end
  endtask

  task automatic check_edges(input int ph, input int d, input int dt);
    int r = PER - d;
    chk(c_hi[d][ph] == 1'b1, "R2 hi before fall", int'(c_hi[d][ph]), 1);
    chk(c_hi[d+1][ph] == 1'b0, "R2 hi after fall", int'(c_hi[d+1][ph]), 0);
    chk(c_lo[d+dt][ph] == 1'b0, "R3 lo gap end", int'(c_lo[d+dt][ph]), 0);
    chk(c_lo[d+dt+1][ph] == 1'b1, "R3 lo on", int'(c_lo[d+dt+1][ph]), 1);
    chk(c_lo[r][ph] == 1'b1, "R2 lo before rise", int'(c_lo[r][ph]), 1);
    chk(c_lo[r+1][ph] == 1'b0, "R2 lo after rise", int'(c_lo[r+1][ph]), 0);
    chk(c_hi[r+dt][ph] == 1'b0, "R3 hi gap end", int'(c_hi[r+dt][ph]), 0);
    chk(c_hi[r+dt+1][ph] == 1'b1, "R3 hi on", int'(c_hi[r+dt+1][ph]), 1);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(gate_hi == 3'b000, "R9 gate_hi", int'(gate_hi), 0);
    chk(gate_lo == 3'b111, "R9 gate_lo", int'(gate_lo), 7);
    chk(!adc_trig && !no_sample, "R9 trig/nosample", int'({adc_trig, no_sample}), 0);
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      int ntr, first, dl [3];
      dl[0] = VEC[v][0]; dl[1] = VEC[v][1]; dl[2] = VEC[v][2];
      duty_u = W'(dl[0]); duty_v = W'(dl[1]); duty_w = W'(dl[2]);
      acq_time = 15'(VEC[v][3]);
      capture(-1, 0);
      ntr = 0; first = -1;
      for (int k = 0; k < PER; k++) if (c_tr[k]) begin ntr++; if (first < 0) first = k; end
      if (VEC[v][4] < 0) begin
        chk(ntr == 0, "R8 no trigger", ntr, 0);
        chk(c_ns[1] && c_ns[PER-1], "R8 no_sample high", int'(c_ns[1]), 1);
      end else begin
        chk(ntr == 1 && first == VEC[v][4], "R7 trigger offset", first, VEC[v][4]);
        chk(!c_ns[1] && !c_ns[PER-1], "R8 no_sample low", int'(c_ns[1]), 0);
      end
      ntr = 0;
      for (int k = 1; k < PER; k++) if (c_rd[k]) ntr++;
      chk(c_rd[0] && ntr == 0, "R1 ready single", ntr, 0);
      for (int p = 0; p < 3; p++)
        if (dl[p] >= D + 2 && dl[p] < MX && dl[p] + D + 1 < PER - dl[p])
          check_edges(p, dl[p], D);
    end

    // R1 period between ready pulses
    begin
      int gap = 0;
      wait_start();
      do begin @(negedge clk); gap++; end while (!ready);
      chk(gap == PER, "R1 period", gap, PER);
    end

    // R5 zero and full duty, steady cycle
    duty_u = W'(MX); duty_v = '0; duty_w = W'(16);
    capture(-1, 0);
    capture(-1, 0);
    begin
      int bad = 0;
      for (int k = 0; k < PER; k++)
        if (!c_hi[k][0] || c_lo[k][0] || c_hi[k][1] || !c_lo[k][1]) bad++;
      chk(bad == 0, "R5 steady full/zero", bad, 0);
    end

    // R6 mid-cycle change deferred
    duty_u = W'(8); duty_v = '0; duty_w = '0;
    capture(-1, 0);
    capture(20, 16);
    chk(c_hi[PER-8+D][0] == 1'b0 && c_hi[PER-8+D+1][0] == 1'b1, "R6 old duty kept",
        int'(c_hi[PER-8+D+1][0]), 1);
    capture(-1, 0);
    chk(c_hi[16][0] == 1'b1 && c_hi[17][0] == 1'b0, "R6 new duty applied",
        int'(c_hi[17][0]), 0);

    // R3 zero dead time
    dead_time = '0; duty_u = W'(8);
    capture(-1, 0);
    capture(-1, 0);
    chk(c_hi[8][0] && !c_lo[8][0], "R3 D0 before edge", int'(c_lo[8][0]), 0);
    chk(!c_hi[9][0] && c_lo[9][0], "R3 D0 swap", int'(c_lo[9][0]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule